// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block drives the command pins of a DDR SDRAM from a system reset to the point where the memory controller can begin normal traffic. It first holds the clock enable low for a programmable power-up delay, counted in clock cycles. It then raises the clock enable, steps through a fixed list of commands and reports completion on `init_done`. That list is: a wake-up NOP, a precharge of all banks, a load of the extended mode register that enables the DLL, and a load of the base mode register with the DLL reset bit set. A second precharge of all banks, two auto refreshes and a last base mode load with DLL reset cleared complete it.

The minimum spacing after each command comes from cycle-count parameters: precharge period, mode register set period and refresh cycle time. The next command is issued exactly that many cycles after the previous one, and NOP fills every cycle in between. A separate lock counter starts at the mode load that resets the DLL. Completion is withheld until that counter has run its full window, even when the command list has already ended.

The burst length code, burst type, CAS latency code and extended register value are parameters. The controller asserts `init_done` and then takes over the bus.

Top module: `ddr_init_seq`

## Requirements
- R1: While synchronous reset `rst` is high, and for PWRUP_CYC cycles after it is released, `cke` is 0, `init_done` is 0 and the command is NOP ({cs_n,ras_n,cas_n,we_n} = 0,1,1,1).
- R2: `cke` rises in the cycle right after the power-up delay, with a NOP on the bus, and stays high until the next reset.
- R3: The non-NOP commands appear in exactly this order: precharge all, extended mode load, base mode load with DLL reset, precharge all, auto refresh, auto refresh, base mode load without DLL reset. No further command follows.
- R4: Precharge all is encoded 0,0,1,0 with `addr[10]` = 1 and every other address bit 0.
- R5: The extended mode load is encoded 0,0,0,0 with `ba` = 2'b01 and `addr` = EXT_MODE.
- R6: The first base mode load is encoded 0,0,0,0 with `ba` = 2'b00. Its address carries the burst length code in bits [2:0], the burst type in bit 3, the CAS latency code in bits [6:4] and bit 8 (DLL reset) set. All other bits are 0.
- R7: The final base mode load carries the same fields as R6 but with bit 8 cleared. Auto refresh is encoded 0,0,0,1.
- R8: The next command starts T_RP cycles after a precharge, T_MRD cycles after a mode load and T_RFC cycles after a refresh. The first precharge comes one cycle after `cke` rises.
- R9: NOP is driven on every cycle between commands and on every cycle after the sequence ends.
- R10: `init_done` rises in the first cycle that is both T_MRD cycles after the final mode load and DLL_LOCK_CYC cycles after the DLL-reset load, and then stays high.
- R11: Asserting `rst` at any point restarts the whole sequence: `cke` goes low, `init_done` clears and the power-up delay begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Sequence complete, memory ready |

## Verification
Two timers can expire in the same cycle: the mode-set period after the last mode load, and the DLL lock window that began at the DLL-reset load. The bench shortens the lock window so that it ends exactly one cycle after the command list finishes. Both expiries then sit on adjacent cycles. `init_done` is judged on the exact cycle it rises, which shows whether completion honours the later of the two timers rather than the command list alone. A reset in the middle of the refresh stage then shows that both timers restart from zero.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int PWRUP_CYC    = 25000,
  parameter int T_RP         = 3,
  parameter int T_MRD        = 2,
  parameter int T_RFC        = 9,
  parameter int DLL_LOCK_CYC = 200,
  parameter int ADDR_W       = 13,
  parameter int BA_W         = 2,
  parameter logic [2:0] BL_CODE = 3'b010,
  parameter logic       BT_SEL  = 1'b0,
  parameter logic [2:0] CL_CODE = 3'b010,
  parameter logic [ADDR_W-1:0] EXT_MODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int M1      = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int M2      = (M1 > T_RFC) ? M1 : T_RFC;
  localparam int MAXLEN  = (M2 > PWRUP_CYC) ? M2 : PWRUP_CYC;
  localparam int CNT_W   = $clog2(MAXLEN + 1);
  localparam int LK_W    = $clog2(DLL_LOCK_CYC + 1);
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'({CL_CODE, BT_SEL, BL_CODE});
  localparam logic [ADDR_W-1:0] DLL_RST   = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  typedef enum logic [3:0] {
    S_WAIT, S_WAKE, S_PRE1, S_EMR, S_MRS_RST,
    S_PRE2, S_REF1, S_REF2, S_MRS_RUN, S_DONE
  } st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [LK_W-1:0]  lk;
  int               seg_len;
  logic             seg_last;
  logic [3:0]       cmd;

  always_comb begin
    case (st)
      S_WAIT:                  seg_len = PWRUP_CYC;
      S_PRE1, S_PRE2:          seg_len = T_RP;
      S_EMR, S_MRS_RST,
      S_MRS_RUN:               seg_len = T_MRD;
      S_REF1, S_REF2:          seg_len = T_RFC;
      default:                 seg_len = 1;
    endcase
  end

  assign seg_last = (cnt == CNT_W'(seg_len - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_WAIT;
      cnt <= '0;
      lk  <= '0;
    end else begin
      if (st != S_DONE) begin
        if (seg_last) begin
          st  <= st_t'(st + 4'd1);
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (st >= S_MRS_RST && lk != LK_W'(DLL_LOCK_CYC))
        lk <= lk + 1'b1;
    end
  end

  always_comb begin
    cmd  = C_NOP;
    ba   = '0;
    addr = '0;
    if (cnt == '0) begin
      case (st)
        S_PRE1, S_PRE2: begin
          cmd  = C_PRE;
          addr = ALL_BANKS;
        end
        S_EMR: begin
          cmd  = C_LMR;
          ba   = BA_W'(1);
          addr = EXT_MODE;
        end
        S_MRS_RST: begin
          cmd  = C_LMR;
          addr = MODE_WORD | DLL_RST;
        end
        S_REF1, S_REF2: cmd = C_REF;
        S_MRS_RUN: begin
          cmd  = C_LMR;
          addr = MODE_WORD;
        end
        default: cmd = C_NOP;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke       = (st != S_WAIT);
  assign init_done = (st == S_DONE) && (lk == LK_W'(DLL_LOCK_CYC));

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);

  logic is_nop, is_pre;
  assign is_nop = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
  assign is_pre = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);

  AST_IDLE_WHILE_LOW: assert property (@(posedge clk) disable iff (rst) !cke |-> is_nop && !init_done); // R1
  AST_CKE_HOLD:       assert property (@(posedge clk) disable iff (rst) cke |=> cke); // R2
  AST_CKE_WAKE_NOP:   assert property (@(posedge clk) disable iff (rst) $rose(cke) |-> is_nop); // R2
  AST_PRE_ALL_BANKS:  assert property (@(posedge clk) disable iff (rst) is_pre |-> addr[10]); // R4
  AST_DONE_STICKY:    assert property (@(posedge clk) disable iff (rst) init_done |=> init_done); // R10
  AST_DONE_QUIET:     assert property (@(posedge clk) disable iff (rst) init_done |-> is_nop && cke); // R9
  AST_RESET_CLEARS:   assert property (@(posedge clk) rst |=> !cke && !init_done); // R11

endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .addr(addr), .init_done(init_done)
);

// File: tb/ddr_init_seq_tb_top.sv
module ddr_init_seq_tb_top;
  localparam int P    = 50;
  localparam int TRP  = 3;
  localparam int TMRD = 2;
  localparam int TRFC = 8;
  localparam int LOCK = 24;
  localparam int AW   = 13;
  localparam logic [2:0] BL = 3'b011;
  localparam logic       BT = 1'b1;
  localparam logic [2:0] CL = 3'b010;
  localparam logic [AW-1:0] EXTV = 13'h0002;

  localparam int I_PRE1 = P + 1;
  localparam int I_EMR  = I_PRE1 + TRP;
  localparam int I_MRS1 = I_EMR + TMRD;
  localparam int I_PRE2 = I_MRS1 + TMRD;
  localparam int I_REF1 = I_PRE2 + TRP;
  localparam int I_REF2 = I_REF1 + TRFC;
  localparam int I_MRS2 = I_REF2 + TRFC;
  localparam int SEQ_END = I_MRS2 + TMRD;
  localparam int DONE_AT = (SEQ_END > I_MRS1 + LOCK) ? SEQ_END : I_MRS1 + LOCK;

  logic clk = 0, rst = 1;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  always #4 clk = ~clk;

  ddr_init_seq #(
    .PWRUP_CYC(P), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC), .DLL_LOCK_CYC(LOCK),
    .ADDR_W(AW), .BA_W(2), .BL_CODE(BL), .BT_SEL(BT), .CL_CODE(CL), .EXT_MODE(EXTV)
  ) dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
  );

  typedef struct {
    int          idx;
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [AW-1:0] addr;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  int idx = 0;
  bit ended = 0;

  localparam logic [AW-1:0] MW = AW'({CL, BT, BL});

  always @(posedge clk) begin
    if (rst) idx <= 0;
    else     idx <= idx + 1;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, idx, act, exp);
    end
  endtask

  task automatic push(input int i, input logic [3:0] c, input logic [1:0] b, input logic [AW-1:0] a, input string t);
    item_t it;
    it.idx = i; it.cmd = c; it.ba = b; it.addr = a; it.tag = t;
    q.push_back(it);
  endtask

  task automatic plan_run();
    q.delete();
    push(I_PRE1, 4'b0010, 2'b00, 13'h0400, "R4");
    push(I_EMR,  4'b0000, 2'b01, EXTV, "R5");
    push(I_MRS1, 4'b0000, 2'b00, MW | 13'h0100, "R6");
    push(I_PRE2, 4'b0010, 2'b00, 13'h0400, "R4");
    push(I_REF1, 4'b0001, 2'b00, '0, "R7");
    push(I_REF2, 4'b0001, 2'b00, '0, "R7");
    push(I_MRS2, 4'b0000, 2'b00, MW, "R7");
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] c;
    c = {cs_n, ras_n, cas_n, we_n};
    check(cke === (idx >= P), (idx >= P) ? "R2" : "R1", "cke", cke, idx >= P);
    check(init_done === (idx >= DONE_AT), (idx >= DONE_AT) ? "R10" : "R1", "init_done", init_done, idx >= DONE_AT);
    if (c === 4'b0111) begin
      check(1'b1, "R9", "nop", c, 4'b0111);
    end else if (q.size() == 0) begin
      check(1'b0, "R3", "unexpected command", c, 4'b0111);
    end else begin
      item_t e;
      e = q.pop_front();
      check(idx == e.idx, "R8", "command cycle", idx, e.idx);
      check(c === e.cmd, "R3", "command code", c, e.cmd);
      check(ba === e.ba, e.tag, "bank", ba, e.ba);
      check(addr === e.addr, e.tag, "address", addr, e.addr);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    plan_run();
    while (idx != I_REF1 + 3) @(negedge clk);
    rst = 1;            // R11 abort in the refresh stage
    q.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cke === 1'b0 && init_done === 1'b0, "R11", "cke/done after reset", {cke, init_done}, 0);
    rst = 0;
    plan_run();
    while (idx != DONE_AT + 20) @(negedge clk);
    check(q.size() == 0, "R3", "commands left", q.size(), 0);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end
endmodule